// File: doc/BRIEF.md
# DMA Channel Destination Address and Acknowledge Unit

This block is the part of one DMA channel that owns the channel's control bits for destination addressing and for the external acknowledge strobe. It holds a small control word written through a register port, steps the destination address once per completed transfer by an amount that follows the transfer size, and drives the acknowledge pin with a programmable polarity and phase placement.

Each transfer is marked by a one-cycle read-phase pulse followed by a one-cycle write-phase pulse. The acknowledge pin follows those pulses combinationally. The address update takes effect on the clock edge after the one that samples the write phase. A prohibited combination of destination mode and transfer size raises a sticky error flag and leaves the address untouched. In single address mode, when the external device is the acknowledged destination, the destination mode is not used at all.

The channel index is a parameter. Only channels 0 and 1 implement the polarity and phase-placement bits. On higher channels those bits are tied to zero.

Top module: `dma_dst_ack_unit`

## Requirements
- R1: Synchronous active-high reset clears the control word, the destination address and the error flag. The acknowledge pin then rests high, because the reset polarity is active-low.
- R2: The control word is 8 bits wide and is laid out as follows. Bits [1:0] hold the destination mode: 00 fixed, 01 increment, 10 decrement, 11 reserved. Bit 2 is the polarity, where 1 means active-high. Bit 3 is the phase placement, where 1 means the write phase. Bits [7:4] always read 0 and ignore writes.
- R3: When CHAN_IDX is 2 or higher, control bits 3 and 2 always read 0 and ignore writes. The pin then behaves as active-low with read-phase placement.
- R4: In increment mode the address rises by 1, 2, 4 or 16 for the sizes byte (code 0), halfword (1), word (2) and 16-byte burst (3).
- R5: In decrement mode the address falls by 1, 2 or 4 for sizes 0, 1 and 2.
- R6: In fixed mode the address does not change after a legal transfer.
- R7: Mode 11, fixed mode with size 3, and decrement mode with size 3 are illegal. Each of them sets the error flag and leaves the address unchanged.
- R8: The error flag stays set until the next control-word write, which clears it.
- R9: In single address mode (dual_mode=0) with dst_is_device=1, the address is not updated and no error is raised, whatever the mode.
- R10: In dual address mode the acknowledge is active during the read phase when bit 3 is 0, and during the write phase when bit 3 is 1.
- R11: In single address mode the acknowledge is active during either phase, whatever bit 3 holds.
- R12: The pin level equals the active state when bit 2 is 1, and its inverse when bit 2 is 0.
- R13: The address update lands on the clock edge after the one that samples wr_phase. It uses 32-bit wraparound arithmetic. A direct address load takes effect on the edge that samples addr_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Control word readback |
| addr_we | input | 1 | Destination address load strobe |
| addr_wdata | input | AW | Destination address load value |
| xfer_size | input | 2 | Transfer size code: 0 byte, 1 halfword, 2 word, 3 16-byte burst |
| dual_mode | input | 1 | 1 for dual address mode, 0 for single |
| dst_is_device | input | 1 | In single mode, the destination is the acknowledged device |
| rd_phase | input | 1 | Read-phase pulse of a transfer |
| wr_phase | input | 1 | Write-phase pulse of a transfer |
| dst_addr | output | AW | Current destination address |
| ack_pin | output | 1 | Acknowledge pin level |
| mode_err | output | 1 | Sticky illegal-mode flag |

## Verification
The hardest situations to reach are the wraparound edges and the suppression paths. These are an increment or decrement that crosses zero, and an illegal mode hidden behind the single-address device case, which must raise no error. Directed transfers load addresses just below zero and just above it. They also issue reserved and burst-size combinations with and without the device case, and then confirm the error is cleared by a control write. Random transfers with random control words, sizes and modes then run against a bench model of the step, the error flag and the pin level. A second instance on channel 2 receives the same stimulus to cover the tied-off control bits.

// File: rtl/dma_ack_pkg.sv
package dma_ack_pkg;

    localparam int CTL_W = 8;

    typedef enum logic [1:0] {
        DST_FIXED = 2'b00,
        DST_INC   = 2'b01,
        DST_DEC   = 2'b10,
        DST_RSVD  = 2'b11
    } dst_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE    = 2'd0,
        SZ_HALF    = 2'd1,
        SZ_WORD    = 2'd2,
        SZ_BURST16 = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic [3:0] rsvd;
        logic       ack_wr_phase;
        logic       ack_high;
        dst_mode_e  dst_mode;
    } ctl_word_t;

    typedef struct packed {
        xfer_size_e size;
        logic       dual;
        logic       dst_dev;
        dst_mode_e  mode;
    } xfer_attr_t;

    function automatic logic [4:0] step_bytes(xfer_size_e s);
        case (s)
            SZ_BYTE:  return 5'd1;
            SZ_HALF:  return 5'd2;
            SZ_WORD:  return 5'd4;
            default:  return 5'd16;
        endcase
    endfunction

    function automatic logic combo_illegal(dst_mode_e m, xfer_size_e s);
        return (m == DST_RSVD) || ((s == SZ_BURST16) && (m != DST_INC));
    endfunction

endpackage

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
    import dma_ack_pkg::*;
#(
    parameter int CHAN_IDX = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  ctl_word_t wdata,
    output ctl_word_t q
);
    localparam bit HAS_ACK_CTL = (CHAN_IDX < 2);

    dst_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= DST_FIXED;
        else if (we)
            mode_q <= wdata.dst_mode;
    end

    generate
        if (HAS_ACK_CTL) begin : g_ack_ctl
            logic wr_ph_q, high_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    wr_ph_q <= 1'b0;
                    high_q  <= 1'b0;
                end else if (we) begin
                    wr_ph_q <= wdata.ack_wr_phase;
                    high_q  <= wdata.ack_high;
                end
            end
            always_comb begin
                q              = '0;
                q.dst_mode     = mode_q;
                q.ack_wr_phase = wr_ph_q;
                q.ack_high     = high_q;
            end
        end else begin : g_no_ack_ctl
            always_comb begin
                q          = '0;
                q.dst_mode = mode_q;
            end
        end
    endgenerate

endmodule

// File: rtl/dma_dst_addr.sv
module dma_dst_addr
    import dma_ack_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_wdata,
    input  logic          wr_phase,
    input  xfer_attr_t    attr_in,
    input  logic          err_clr,
    output logic [AW-1:0] addr,
    output logic          err
);
    logic          pend_q;
    xfer_attr_t    attr_q;
    logic          skip, bad;
    logic [AW-1:0] step;
    logic [AW-1:0] addr_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            attr_q <= '0;
        end else begin
            pend_q <= wr_phase;
            if (wr_phase)
                attr_q <= attr_in;
        end
    end

    always_comb begin
        skip      = !attr_q.dual && attr_q.dst_dev;
        bad       = !skip && combo_illegal(attr_q.mode, attr_q.size);
        step      = AW'(step_bytes(attr_q.size));
        addr_next = addr;
        if (!skip && !bad) begin
            case (attr_q.mode)
                DST_INC: addr_next = addr + step;
                DST_DEC: addr_next = addr - step;
                default: addr_next = addr;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            err  <= 1'b0;
        end else begin
            if (addr_we)
                addr <= addr_wdata;
            else if (pend_q)
                addr <= addr_next;

            if (pend_q && bad && !addr_we)
                err <= 1'b1;
            else if (err_clr)
                err <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_ack_gen.sv
module dma_ack_gen (
    input  logic rd_phase,
    input  logic wr_phase,
    input  logic dual,
    input  logic place_wr,
    input  logic act_high,
    output logic pin
);
    logic active;

    always_comb begin
        if (dual)
            active = place_wr ? wr_phase : rd_phase;
        else
            active = rd_phase | wr_phase;
        pin = act_high ? active : !active;
    end

endmodule

// File: rtl/dma_dst_ack_unit.sv
module dma_dst_ack_unit
    import dma_ack_pkg::*;
#(
    parameter int CHAN_IDX = 0,
    parameter int AW       = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_wdata,
    input  logic [1:0]    xfer_size,
    input  logic          dual_mode,
    input  logic          dst_is_device,
    input  logic          rd_phase,
    input  logic          wr_phase,
    output logic [AW-1:0] dst_addr,
    output logic          ack_pin,
    output logic          mode_err
);
    ctl_word_t  ctl_q;
    xfer_attr_t attr;

    dma_ctl_reg #(.CHAN_IDX(CHAN_IDX)) ctl_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (ctl_word_t'(cfg_wdata)),
        .q     (ctl_q)
    );

    assign cfg_rdata = ctl_q;

    always_comb begin
        attr.size    = xfer_size_e'(xfer_size);
        attr.dual    = dual_mode;
        attr.dst_dev = dst_is_device;
        attr.mode    = ctl_q.dst_mode;
    end

    dma_dst_addr #(.AW(AW)) addr_i (
        .clk        (clk),
        .rst        (rst),
        .addr_we    (addr_we),
        .addr_wdata (addr_wdata),
        .wr_phase   (wr_phase),
        .attr_in    (attr),
        .err_clr    (cfg_we),
        .addr       (dst_addr),
        .err        (mode_err)
    );

    dma_ack_gen ack_i (
        .rd_phase (rd_phase),
        .wr_phase (wr_phase),
        .dual     (dual_mode),
        .place_wr (ctl_q.ack_wr_phase),
        .act_high (ctl_q.ack_high),
        .pin      (ack_pin)
    );

endmodule

// File: rtl/dma_dst_ack_unit_chk.sv
module dma_dst_ack_unit_chk #(
    parameter int CHAN_IDX = 0,
    parameter int AW       = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [7:0]    cfg_rdata,
    input logic          addr_we,
    input logic          rd_phase,
    input logic          wr_phase,
    input logic [AW-1:0] dst_addr,
    input logic          ack_pin,
    input logic          mode_err
);
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[7:4] == 4'b0);

    generate
        if (CHAN_IDX >= 2) begin : g_hi
            assert_ack_bits_tied_R3: assert property (@(posedge clk) disable iff (rst)
                cfg_rdata[3:2] == 2'b0);
        end
    endgenerate

    assert_err_blocks_update_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_err) |-> $stable(dst_addr));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_err && !cfg_we) |=> mode_err);

    assert_update_timing_R13: assert property (@(posedge clk) disable iff (rst)
        (!wr_phase ##1 !addr_we) |=> $stable(dst_addr));

    assert_idle_level_R12: assert property (@(posedge clk) disable iff (rst)
        (!rd_phase && !wr_phase) |-> (ack_pin == !cfg_rdata[2]));

endmodule

bind dma_dst_ack_unit dma_dst_ack_unit_chk #(.CHAN_IDX(CHAN_IDX), .AW(AW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_rdata (cfg_rdata),
    .addr_we   (addr_we),
    .rd_phase  (rd_phase),
    .wr_phase  (wr_phase),
    .dst_addr  (dst_addr),
    .ack_pin   (ack_pin),
    .mode_err  (mode_err)
);

// File: tb/dma_dst_ack_unit_tb_top.sv
`timescale 1ns/1ps
module dma_dst_ack_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        addr_we = 1'b0;
    logic [31:0] addr_wdata = '0;
    logic [1:0]  xfer_size = '0;
    logic        dual_mode = 1'b0;
    logic        dst_is_device = 1'b0;
    logic        rd_phase = 1'b0;
    logic        wr_phase = 1'b0;

    logic [7:0]  rdata_lo, rdata_hi;
    logic [31:0] addr_lo, addr_hi;
    logic        ack_lo, ack_hi, err_lo, err_hi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  m_ctl_lo, m_ctl_hi;
    logic [31:0] m_addr;
    logic        m_err;

    always #2 clk = ~clk;

    dma_dst_ack_unit #(.CHAN_IDX(0), .AW(32)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_lo),
        .addr_we(addr_we), .addr_wdata(addr_wdata), .xfer_size(xfer_size),
        .dual_mode(dual_mode), .dst_is_device(dst_is_device), .rd_phase(rd_phase),
        .wr_phase(wr_phase), .dst_addr(addr_lo), .ack_pin(ack_lo), .mode_err(err_lo));

    dma_dst_ack_unit #(.CHAN_IDX(2), .AW(32)) dut_hi_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_hi),
        .addr_we(addr_we), .addr_wdata(addr_wdata), .xfer_size(xfer_size),
        .dual_mode(dual_mode), .dst_is_device(dst_is_device), .rd_phase(rd_phase),
        .wr_phase(wr_phase), .dst_addr(addr_hi), .ack_pin(ack_hi), .mode_err(err_hi));

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_pin(input logic [7:0] ctl, input logic dual, input logic rd, input logic wr);
        logic active;
        if (dual) active = ctl[3] ? wr : rd;
        else      active = rd | wr;
        return ctl[2] ? active : !active;
    endfunction

    function automatic int step_of(input logic [1:0] sz);
        case (sz)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 16;
        endcase
    endfunction

    task automatic model_xfer(input logic [1:0] sz, input logic dual, input logic dev);
        logic [1:0] md;
        md = m_ctl_lo[1:0];
        if (!dual && dev) return;
        if (md == 2'b11 || (sz == 2'd3 && md != 2'b01)) begin
            m_err = 1'b1;
            return;
        end
        if (md == 2'b01) m_addr = m_addr + 32'(step_of(sz));
        else if (md == 2'b10) m_addr = m_addr - 32'(step_of(sz));
    endtask

    task automatic write_cfg(input logic [7:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        m_ctl_lo = d & 8'h0F;
        m_ctl_hi = d & 8'h03;
        m_err = 1'b0;
        check(rdata_lo == m_ctl_lo, "R2 readback", 32'(rdata_lo), 32'(m_ctl_lo));
        check(rdata_hi == m_ctl_hi, "R3 readback ch2", 32'(rdata_hi), 32'(m_ctl_hi));
        check(err_lo == 1'b0, "R8 clear on write", 32'(err_lo), 32'd0);
    endtask

    task automatic load_addr(input logic [31:0] a);
        addr_we = 1'b1; addr_wdata = a;
        @(negedge clk);
        addr_we = 1'b0;
        m_addr = a;
        check(addr_lo == a, "R13 load", addr_lo, a);
    endtask

    task automatic xfer(input logic [1:0] sz, input logic dual, input logic dev, input string tag);
        xfer_size = sz; dual_mode = dual; dst_is_device = dev;
        rd_phase = 1'b1;
        #1;
        check(ack_lo == exp_pin(m_ctl_lo, dual, 1, 0), dual ? "R10 rd pin" : "R11 rd pin", 32'(ack_lo), 32'(exp_pin(m_ctl_lo, dual, 1, 0)));
        check(ack_hi == exp_pin(m_ctl_hi, dual, 1, 0), "R3 rd pin ch2", 32'(ack_hi), 32'(exp_pin(m_ctl_hi, dual, 1, 0)));
        @(negedge clk);
        rd_phase = 1'b0; wr_phase = 1'b1;
        #1;
        check(ack_lo == exp_pin(m_ctl_lo, dual, 0, 1), dual ? "R10 wr pin" : "R11 wr pin", 32'(ack_lo), 32'(exp_pin(m_ctl_lo, dual, 0, 1)));
        check(ack_hi == exp_pin(m_ctl_hi, dual, 0, 1), "R3 wr pin ch2", 32'(ack_hi), 32'(exp_pin(m_ctl_hi, dual, 0, 1)));
        @(negedge clk);
        wr_phase = 1'b0;
        check(addr_lo == m_addr, "R13 no early update", addr_lo, m_addr);
        model_xfer(sz, dual, dev);
        @(negedge clk);
        check(addr_lo == m_addr, tag, addr_lo, m_addr);
        check(err_lo == m_err, tag, 32'(err_lo), 32'(m_err));
        check(addr_hi == m_addr, "R13 ch2 addr", addr_hi, m_addr);
        check(ack_lo == exp_pin(m_ctl_lo, dual, 0, 0), "R12 idle pin", 32'(ack_lo), 32'(exp_pin(m_ctl_lo, dual, 0, 0)));
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_ctl_lo = '0; m_ctl_hi = '0; m_addr = '0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rdata_lo == 8'h00, "R1 ctl", 32'(rdata_lo), 32'd0);
        check(addr_lo == 32'h0, "R1 addr", addr_lo, 32'd0);
        check(err_lo == 1'b0, "R1 err", 32'(err_lo), 32'd0);
        check(ack_lo == 1'b1, "R1 pin", 32'(ack_lo), 32'd1);

        // R2 reserved bits and R3 tie-off
        write_cfg(8'hFF);
        write_cfg(8'h01);

        // R4 increments incl. wrap
        load_addr(32'hFFFF_FFF8);
        xfer(2'd3, 1, 0, "R4 burst inc wrap");
        xfer(2'd0, 1, 0, "R4 byte inc");
        xfer(2'd1, 1, 0, "R4 half inc");
        xfer(2'd2, 1, 0, "R4 word inc");

        // R5 decrements incl. wrap
        write_cfg(8'h02);
        load_addr(32'h0000_0002);
        xfer(2'd2, 1, 0, "R5 word dec wrap");
        xfer(2'd1, 1, 0, "R5 half dec");
        xfer(2'd0, 1, 0, "R5 byte dec");

        // R6 fixed
        write_cfg(8'h00);
        xfer(2'd2, 1, 0, "R6 fixed");

        // R7 illegal combos, R8 sticky then cleared
        xfer(2'd3, 1, 0, "R7 fixed burst");
        xfer(2'd0, 1, 0, "R8 sticky");
        write_cfg(8'h02);
        xfer(2'd3, 1, 0, "R7 dec burst");
        write_cfg(8'h03);
        xfer(2'd1, 1, 0, "R7 reserved mode");

        // R9 single device destination ignores mode
        write_cfg(8'h03);
        xfer(2'd3, 0, 1, "R9 single dev reserved");
        write_cfg(8'h01);
        xfer(2'd2, 0, 1, "R9 single dev inc");
        xfer(2'd2, 0, 0, "R11 single mem inc");

        // R10/R12 placement and polarity
        write_cfg(8'h05);
        xfer(2'd0, 1, 0, "R12 high rd");
        write_cfg(8'h0D);
        xfer(2'd0, 1, 0, "R10 high wr");
        write_cfg(8'h09);
        xfer(2'd0, 1, 0, "R10 low wr");
        xfer(2'd0, 0, 0, "R11 single low wr bit");

        // random mix
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 2) == 0) write_cfg(8'($urandom));
            if ($urandom_range(0, 4) == 0) load_addr($urandom);
            xfer(2'($urandom), 1'($urandom), 1'($urandom), "R4 random xfer");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule